// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches a bank of raw GPIO input pins, turns level or edge conditions on each pin into latched pending bits, and drives one combined interrupt line for a processor. Software reaches it through a single-cycle register bus. Through that bus it sets per-pin enable, direction, pull-enable and pull-select bits, which leave the block as plain outputs for the pad ring. It also writes a packed byte of trigger configuration for each pin, and reads or clears the pending bits.

Each pin's input passes through a synchronizer before an event detector looks at it. Each pin's configuration byte selects one of five trigger conditions and carries an interrupt-enable flag in its top bit. A pending bit is set whenever its pin's trigger condition holds, whatever the enable flag says. The interrupt output is high while any pending bit has its enable flag set. To retarget a pin, software clears the enable flag, rewrites the trigger code, and then clears the pin's pending bit.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the enable, direction, pull-enable, pull-select and configuration registers read as zero, `irq` is low and `bus_rdata` is zero.
- R2: The enable (offset 0x00), direction (0x04), pull-enable (0x08) and pull-select (0x0C) registers hold one bit per pin in bits [NUM_PINS-1:0]. They drive `pin_en`, `pin_dir`, `pull_en` and `pull_up` directly, a pull-select of 1 meaning pull-up. Bits at and above NUM_PINS read as zero.
- R3: Pin p owns the byte at bits [8*(p%4)+7 : 8*(p%4)] of the configuration word at offset 0x40 + 4*(p/4). All eight bits read back as written, byte lanes that belong to no pin read as zero, and a field changes only when its word is written.
- R4: Trigger code 000 (bits [2:0]) is level-low and 001 is level-high. The pending bit is set on every cycle the active level is present, so a clear has no lasting effect while the level persists. Once the level goes away the bit stays set until it is cleared.
- R5: Code 010 is falling-edge and 011 is rising-edge. One transition in the selected direction sets the pending bit once, and a transition in the other direction sets nothing.
- R6: Code 100 sets the pending bit on both rising and falling transitions.
- R7: Codes 101, 110 and 111 never set a pending bit, and bits [6:3] of a field have no effect on detection.
- R8: The pending register at offset 0x10 holds one bit per pin. Writing 1 to a bit clears it unless an event for that pin occurs in the same cycle, and writing 0 leaves the bit unchanged.
- R9: Pending bits are set whatever bit 7 of the field holds. `irq` is the OR over all pins of pending AND bit 7, so setting bit 7 on a pin that is already pending raises `irq`.
- R10: A pin change driven before rising edge k sets its pending bit at edge k+2, and with IRQ_REG=0 `irq` follows in that same cycle.
- R11: A read presented with `bus_rd` at a rising edge returns, on `bus_rdata` after that edge, the register value from before that edge, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_en | output | NUM_PINS | Per-pin GPIO enable |
| pin_dir | output | NUM_PINS | Per-pin direction, 0 = input |
| pull_en | output | NUM_PINS | Per-pin pull enable |
| pull_up | output | NUM_PINS | Per-pin pull select, 1 = up |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with NUM_PINS=6 and the other parameters at their defaults, including the two-stage synchronizer and the combinational interrupt output. Six pins need two configuration words, and the second word has two lanes that belong to no pin. That puts lane packing, lane zeroing and the masking of upper register bits within reach, while every trigger code can still sit on its own pin. A bench reference model tracks the synchronizer, the pending bits and the enables cycle by cycle, so long random runs of pin toggles, configuration rewrites and clears can be compared against `irq` on every cycle and against periodic pending reads.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int BUS_W          = 32;
   localparam int FIELD_W        = 8;
   localparam int LANES_PER_WORD = BUS_W / FIELD_W;
   localparam int IRQ_EN_BIT     = 7;
   localparam int TRIG_W         = 3;

   typedef enum logic [TRIG_W-1:0] {
      TRIG_LVL_LO = 3'd0,
      TRIG_LVL_HI = 3'd1,
      TRIG_FALL   = 3'd2,
      TRIG_RISE   = 3'd3,
      TRIG_BOTH   = 3'd4
   } trig_e;

   // Decide whether a pin's trigger condition holds this cycle.
   function automatic logic trig_fire(input logic [TRIG_W-1:0] code,
                                      input logic now_v,
                                      input logic old_v);
      logic hit;
      case (code)
         TRIG_LVL_LO: hit = !now_v;
         TRIG_LVL_HI: hit = now_v;
         TRIG_FALL:   hit = old_v && !now_v;
         TRIG_RISE:   hit = !old_v && now_v;
         TRIG_BOTH:   hit = old_v ^ now_v;
         default:     hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int WIDTH  = 20,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_irq_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int WIDTH = 20
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [WIDTH-1:0]             lvl,
   input  logic [WIDTH-1:0][TRIG_W-1:0] code,
   output logic [WIDTH-1:0]             evt
);

   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign evt[i] = trig_fire(code[i], lvl[i], prev[i]);

      AST_RISE_NEEDS_LOW_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
         (code[i] == TRIG_RISE && evt[i]) |-> (lvl[i] && !$past(lvl[i]))); // R5
      AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (code[i] > TRIG_BOTH) |-> !evt[i]); // R7
   end

endmodule

// File: rtl/gpio_irq_pend.sv
module gpio_irq_pend #(
   parameter int WIDTH   = 20,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic [WIDTH-1:0] clr,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] pend,
   output logic             irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr) | evt;
   end

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |(pend & mask);
      end
   end else begin : g_irq_comb
      assign irq = |(pend & mask);
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> pend[i]); // R4
      AST_NO_SET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
         (!pend[i] && !evt[i]) |=> !pend[i]); // R7
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !evt[i]) |=> !pend[i]); // R8
      AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         (pend[i] && !clr[i]) |=> pend[i]); // R8
   end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int WIDTH        = 20,
   parameter int ADDR_W       = 12,
   parameter int OFF_EN       = 'h000,
   parameter int OFF_DIR      = 'h004,
   parameter int OFF_PULL_EN  = 'h008,
   parameter int OFF_PULL_SEL = 'h00C,
   parameter int OFF_PEND     = 'h010,
   parameter int OFF_CFG      = 'h040
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [BUS_W-1:0]              bus_wdata,
   output logic [BUS_W-1:0]              bus_rdata,
   input  logic [WIDTH-1:0]              pend,
   output logic [WIDTH-1:0]              pend_clr,
   output logic [WIDTH-1:0]              en_q,
   output logic [WIDTH-1:0]              dir_q,
   output logic [WIDTH-1:0]              pe_q,
   output logic [WIDTH-1:0]              ps_q,
   output logic [WIDTH-1:0][FIELD_W-1:0] cfg_q
);

   localparam int NUM_CFG = (WIDTH + LANES_PER_WORD - 1) / LANES_PER_WORD;
   localparam int CFG_END = OFF_CFG + 4 * NUM_CFG;

   if (WIDTH < 1 || WIDTH > BUS_W) begin : g_bad_width
      $error("gpio_irq_regs: WIDTH must be 1..32");
   end
   if ((OFF_EN % 4) != 0 || (OFF_DIR % 4) != 0 || (OFF_PULL_EN % 4) != 0 ||
       (OFF_PULL_SEL % 4) != 0 || (OFF_PEND % 4) != 0 || (OFF_CFG % 4) != 0) begin : g_bad_align
      $error("gpio_irq_regs: register offsets must be word aligned");
   end
   if (CFG_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_irq_regs: ADDR_W too small for the configuration window");
   end

   logic hit_en, hit_dir, hit_pe, hit_ps, hit_pend;

   assign hit_en   = bus_wr && (bus_addr == ADDR_W'(OFF_EN));
   assign hit_dir  = bus_wr && (bus_addr == ADDR_W'(OFF_DIR));
   assign hit_pe   = bus_wr && (bus_addr == ADDR_W'(OFF_PULL_EN));
   assign hit_ps   = bus_wr && (bus_addr == ADDR_W'(OFF_PULL_SEL));
   assign hit_pend = bus_wr && (bus_addr == ADDR_W'(OFF_PEND));

   assign pend_clr = hit_pend ? bus_wdata[WIDTH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         dir_q <= '0;
         pe_q  <= '0;
         ps_q  <= '0;
      end else begin
         if (hit_en)  en_q  <= bus_wdata[WIDTH-1:0];
         if (hit_dir) dir_q <= bus_wdata[WIDTH-1:0];
         if (hit_pe)  pe_q  <= bus_wdata[WIDTH-1:0];
         if (hit_ps)  ps_q  <= bus_wdata[WIDTH-1:0];
      end
   end

   // One byte lane per pin; pin i sits in word i/4, lane i%4.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (bus_wr) begin
         for (int i = 0; i < WIDTH; i++) begin
            if (bus_addr == ADDR_W'(OFF_CFG + 4 * (i / LANES_PER_WORD)))
               cfg_q[i] <= bus_wdata[(i % LANES_PER_WORD) * FIELD_W +: FIELD_W];
         end
      end
   end

   logic [NUM_CFG-1:0][BUS_W-1:0] cfg_word;

   always_comb begin
      cfg_word = '0;
      for (int i = 0; i < WIDTH; i++) begin
         cfg_word[i / LANES_PER_WORD][(i % LANES_PER_WORD) * FIELD_W +: FIELD_W] = cfg_q[i];
      end
   end

   logic [BUS_W-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(OFF_EN))       rd_mux = BUS_W'(en_q);
      if (bus_addr == ADDR_W'(OFF_DIR))      rd_mux = BUS_W'(dir_q);
      if (bus_addr == ADDR_W'(OFF_PULL_EN))  rd_mux = BUS_W'(pe_q);
      if (bus_addr == ADDR_W'(OFF_PULL_SEL)) rd_mux = BUS_W'(ps_q);
      if (bus_addr == ADDR_W'(OFF_PEND))     rd_mux = BUS_W'(pend);
      for (int k = 0; k < NUM_CFG; k++) begin
         if (bus_addr == ADDR_W'(OFF_CFG + 4 * k)) rd_mux = cfg_word[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   AST_EN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_en |=> (en_q == $past(bus_wdata[WIDTH-1:0]))); // R2
   AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(cfg_q)); // R3
   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R11

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS     = 20,
   parameter int ADDR_W       = 12,
   parameter int SYNC_STAGES  = 2,
   parameter bit IRQ_REG      = 1'b0,
   parameter int OFF_EN       = 'h000,
   parameter int OFF_DIR      = 'h004,
   parameter int OFF_PULL_EN  = 'h008,
   parameter int OFF_PULL_SEL = 'h00C,
   parameter int OFF_PEND     = 'h010,
   parameter int OFF_CFG      = 'h040
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_en,
   output logic [NUM_PINS-1:0] pin_dir,
   output logic [NUM_PINS-1:0] pull_en,
   output logic [NUM_PINS-1:0] pull_up,
   output logic                irq
);

   logic [NUM_PINS-1:0]              lvl_sync;
   logic [NUM_PINS-1:0]              evt;
   logic [NUM_PINS-1:0]              pend;
   logic [NUM_PINS-1:0]              pend_clr;
   logic [NUM_PINS-1:0]              irq_mask;
   logic [NUM_PINS-1:0][FIELD_W-1:0] cfg;
   logic [NUM_PINS-1:0][TRIG_W-1:0]  trig_code;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_field
      assign trig_code[i] = cfg[i][TRIG_W-1:0];
      assign irq_mask[i]  = cfg[i][IRQ_EN_BIT];
   end

   gpio_irq_regs #(
      .WIDTH(NUM_PINS), .ADDR_W(ADDR_W),
      .OFF_EN(OFF_EN), .OFF_DIR(OFF_DIR), .OFF_PULL_EN(OFF_PULL_EN),
      .OFF_PULL_SEL(OFF_PULL_SEL), .OFF_PEND(OFF_PEND), .OFF_CFG(OFF_CFG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pend(pend), .pend_clr(pend_clr),
      .en_q(pin_en), .dir_q(pin_dir), .pe_q(pull_en), .ps_q(pull_up),
      .cfg_q(cfg)
   );

   gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
   );

   gpio_irq_detect #(.WIDTH(NUM_PINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .code(trig_code), .evt(evt)
   );

   gpio_irq_pend #(.WIDTH(NUM_PINS), .IRQ_REG(IRQ_REG)) u_pend (
      .clk(clk), .rst_n(rst_n), .evt(evt), .clr(pend_clr),
      .mask(irq_mask), .pend(pend), .irq(irq)
   );

   if (IRQ_REG) begin : g_chk_reg
      AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $past(|pend)); // R9
   end else begin : g_chk_comb
      AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> (|pend)); // R9
   end

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;

   localparam int NP = 6;
   localparam int AW = 12;
   localparam logic [AW-1:0] A_EN   = 12'h000;
   localparam logic [AW-1:0] A_DIR  = 12'h004;
   localparam logic [AW-1:0] A_PE   = 12'h008;
   localparam logic [AW-1:0] A_PS   = 12'h00C;
   localparam logic [AW-1:0] A_PEND = 12'h010;
   localparam logic [AW-1:0] A_CFG0 = 12'h040;
   localparam logic [AW-1:0] A_CFG1 = 12'h044;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pins = '1;
   logic [NP-1:0] pin_en, pin_dir, pull_en, pull_up;
   logic          irq;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  mon_on = 1'b0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pins), .pin_en(pin_en), .pin_dir(pin_dir),
      .pull_en(pull_en), .pull_up(pull_up), .irq(irq)
   );

   // Reference model built from the requirements.
   logic [NP-1:0] m_s1, m_s2, m_p, m_pend, m_ev, m_clr;
   logic [7:0]    m_cfg [NP];

   function automatic logic ref_hit(logic [2:0] c, logic cur, logic prv);
      case (c)
         3'd0:    return !cur;
         3'd1:    return cur;
         3'd2:    return prv && !cur;
         3'd3:    return !prv && cur;
         3'd4:    return prv != cur;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic ref_irq();
      logic r = 1'b0;
      for (int i = 0; i < NP; i++) r |= m_pend[i] & m_cfg[i][7];
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_pend <= '0;
         for (int i = 0; i < NP; i++) m_cfg[i] <= '0;
      end else begin
         for (int i = 0; i < NP; i++) m_ev[i] = ref_hit(m_cfg[i][2:0], m_s2[i], m_p[i]);
         m_clr = (bus_wr && bus_addr == A_PEND) ? bus_wdata[NP-1:0] : '0;
         m_pend <= (m_pend & ~m_clr) | m_ev;
         if (bus_wr) begin
            for (int i = 0; i < NP; i++) begin
               if (bus_addr == A_CFG0 + 12'(4 * (i / 4))) m_cfg[i] <= bus_wdata[8*(i%4) +: 8];
            end
         end
         m_s1 <= pins; m_s2 <= m_s1; m_p <= m_s2;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on && !done) check("R9 irq vs pending&enable", 32'(irq), 32'(ref_irq()));
   end

   task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic read_check(string req, logic [AW-1:0] a, logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(req, d, exp);
   endtask

   task automatic read_pend_vs_model();
      logic [31:0] exp;
      @(negedge clk); bus_rd = 1'b1; bus_addr = A_PEND; exp = 32'(m_pend);
      @(negedge clk); bus_rd = 1'b0;
      check("R8 pending vs model", bus_rdata, exp);
   endtask

   task automatic set_pin(int i, logic v);
      @(negedge clk); pins[i] = v;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int r;
      r = $urandom(32'h1357);
      idle(5);
      check("R1 rdata at reset", bus_rdata, 32'h0);
      check("R1 irq at reset", 32'(irq), 32'h0);
      @(negedge clk); rst_n = 1'b1;
      mon_on = 1'b1;
      read_check("R1 enable reset", A_EN, 32'h0);
      read_check("R1 direction reset", A_DIR, 32'h0);
      read_check("R1 pull enable reset", A_PE, 32'h0);
      read_check("R1 pull select reset", A_PS, 32'h0);
      read_check("R1 cfg0 reset", A_CFG0, 32'h0);
      read_check("R1 cfg1 reset", A_CFG1, 32'h0);

      // Quiet baseline: reserved codes, masked.
      bus_write(A_CFG0, 32'h0707_0707);
      bus_write(A_CFG1, 32'h0000_0707);
      idle(2);
      bus_write(A_PEND, 32'h3F);
      read_check("R8 pending cleared", A_PEND, 32'h0);

      // R2 plain registers and their outputs
      bus_write(A_EN,  32'hFFFF_FFD5);
      bus_write(A_DIR, 32'h0000_002A);
      bus_write(A_PE,  32'h8000_0033);
      bus_write(A_PS,  32'h0000_000F);
      read_check("R2 enable readback masked", A_EN, 32'h15);
      read_check("R2 direction readback", A_DIR, 32'h2A);
      read_check("R2 pull enable readback", A_PE, 32'h33);
      read_check("R2 pull select readback", A_PS, 32'h0F);
      check("R2 pin_en", 32'(pin_en), 32'h15);
      check("R2 pin_dir", 32'(pin_dir), 32'h2A);
      check("R2 pull_en", 32'(pull_en), 32'h33);
      check("R2 pull_up", 32'(pull_up), 32'h0F);

      // R4 level high on pin0
      bus_write(A_CFG0, 32'h0707_0781);
      idle(3);
      read_check("R4 level high sets", A_PEND, 32'h01);
      check("R9 irq on enabled pending", 32'(irq), 32'h1);
      bus_write(A_PEND, 32'h01);
      read_check("R4 clear ineffective while level held", A_PEND, 32'h01);
      set_pin(0, 1'b0);
      idle(4);
      read_check("R4 stays set after level gone", A_PEND, 32'h01);
      bus_write(A_PEND, 32'h01);
      read_check("R8 write one clears", A_PEND, 32'h00);
      // R4 level low
      bus_write(A_CFG0, 32'h0707_0780);
      idle(3);
      read_check("R4 level low sets", A_PEND, 32'h01);
      set_pin(0, 1'b1);
      idle(4);
      bus_write(A_PEND, 32'h01);
      read_check("R4 cleared after level low gone", A_PEND, 32'h00);

      // R5 rising on pin1, R10 latency
      bus_write(A_CFG0, 32'h0707_8307);
      set_pin(1, 1'b0);
      idle(4);
      read_check("R5 falling ignored in rising mode", A_PEND, 32'h00);
      @(negedge clk); pins[1] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R10 irq not yet after two edges", 32'(irq), 32'h0);
      @(posedge clk);
      @(negedge clk);
      check("R10 irq after third edge", 32'(irq), 32'h1);
      idle(3);
      read_check("R5 rising sets once", A_PEND, 32'h02);
      bus_write(A_PEND, 32'h02);
      read_check("R5 no reset while high", A_PEND, 32'h00);

      // R5 falling on pin2 with enable off, R9
      bus_write(A_CFG0, 32'h0702_0707);
      set_pin(2, 1'b0);
      idle(4);
      read_check("R5 falling sets", A_PEND, 32'h04);
      check("R9 masked pending keeps irq low", 32'(irq), 32'h0);
      bus_write(A_CFG0, 32'h0782_0707);
      check("R9 enabling pending raises irq", 32'(irq), 32'h1);
      bus_write(A_PEND, 32'h04);
      set_pin(2, 1'b1);
      idle(4);
      read_check("R5 rising ignored in falling mode", A_PEND, 32'h00);

      // R6 both edges on pin3, R8 write zero
      bus_write(A_CFG0, 32'h8407_0707);
      set_pin(3, 1'b0);
      idle(4);
      read_check("R6 falling edge seen", A_PEND, 32'h08);
      bus_write(A_PEND, 32'h37);
      read_check("R8 write zero keeps bit", A_PEND, 32'h08);
      bus_write(A_PEND, 32'h08);
      set_pin(3, 1'b1);
      idle(4);
      read_check("R6 rising edge seen", A_PEND, 32'h08);
      bus_write(A_PEND, 32'h08);
      read_check("R8 cleared", A_PEND, 32'h00);

      // R7 reserved codes on pins 4 and 5
      bus_write(A_CFG1, 32'h0000_8685);
      set_pin(4, 1'b0); set_pin(5, 1'b0);
      idle(4);
      set_pin(4, 1'b1); set_pin(5, 1'b1);
      idle(4);
      read_check("R7 reserved codes silent", A_PEND, 32'h00);
      check("R7 irq quiet", 32'(irq), 32'h0);

      // R3 packing, upper bits stored, R7 upper bits inert
      bus_write(A_CFG1, 32'hABCD_87FB);
      read_check("R3 cfg1 readback with empty lanes", A_CFG1, 32'h0000_87FB);
      read_check("R3 cfg0 readback", A_CFG0, 32'h8407_0707);
      set_pin(4, 1'b0);
      idle(4);
      read_check("R7 upper bits do not alter rising", A_PEND, 32'h00);
      set_pin(4, 1'b1);
      idle(4);
      read_check("R7 rising with upper bits set", A_PEND, 32'h10);
      bus_write(A_PEND, 32'h3F);
      read_check("R11 read returns pre-edge value", A_PEND, 32'h00);

      // Random phase checked against the model.
      for (int n = 0; n < 3000; n++) begin
         r = int'($urandom % 10);
         case (r)
            0, 1, 2: begin
               int k = int'($urandom % NP);
               @(negedge clk); pins[k] = ~pins[k];
            end
            3: bus_write(($urandom % 2) ? A_CFG1 : A_CFG0, $urandom);
            4: bus_write(A_PEND, $urandom);
            5: read_pend_vs_model();
            default: idle(1);
         endcase
      end
      idle(4);
      read_pend_vs_model();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule